// File: doc/BRIEF.md
# Statically Routed Mesh Tile Switch

This block is the switch in each tile of a two-dimensional mesh of small processors. Every edge of the tile (north, east, south, west) has a switch link in each direction. Each edge also has an incoming neighbour link. Words that cross the tile from one edge to another are held in only one register per output edge. Words bound for the local core collect in two deep FIFOs, so a two-operand instruction can take one operand from each FIFO.

No word carries routing information. A small configuration store, written while the tile is held idle, picks the source of every output. The outputs are the four outgoing switch links and the two core FIFOs. A source may feed several outputs at once. It is then consumed only when all of them can take the word. Every hop uses a valid/ready handshake, so words are never lost or repeated. A word that crosses k tiles therefore spends k register stages in transit.

Top module: `mesh_tile_router`

## Requirements
- R1: After reset, every select is 0 (none) and both neighbour-mode bits are 0. No outgoing switch link is valid, both FIFOs are empty, and every input ready (switch, neighbour, core output) is low, including after enable is raised.
- R2: A configuration write (cfg_we) takes effect only while en is low. A write made while en is high leaves the routing unchanged. Address 0..3 selects the source of the outgoing switch link of edge N, E, S, W. Address 4 and address 5 select the sources of FIFO A and FIFO B. Address 6 loads the neighbour-mode bits from cfg_sel[1:0]: bit 0 is FIFO A and bit 1 is FIFO B. Select codes are 0 = none, 1 = north, 2 = east, 3 = south, 4 = west and 5 = core output. Edge index 0..3 is N, E, S, W in every port vector.
- R3: A word accepted on a switch input (or on the core output) at a clock edge is valid on every outgoing switch link that selects it right after that edge, with the same data. This is exactly one register stage.
- R4: A transit register whose downstream is not ready holds its word stable and refuses new input. When the downstream becomes ready, the old word leaves and a new word can load at the same edge.
- R5: A source selected by several outputs is accepted only when every selected output can take a word. The word is then delivered to all of them.
- R6: Each core FIFO holds 32 words of 16 bits in arrival order. It accepts words while not full and drives its source's ready low when full.
- R7: A read request on an empty FIFO is ignored. The FIFO stays empty, and a later word is read correctly.
- R8: With a FIFO's neighbour-mode bit set, codes 1..4 take the word from that edge's incoming neighbour link instead of its switch link. A word reaches the FIFO in one cycle.
- R9: Code 5 routes the core output to outgoing switch links or to a FIFO (loopback).
- R10: While en is low, or while no output selects a source, that source's ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; configuration only while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration entry (0..6) |
| cfg_sel | input | 3 | Select code or neighbour-mode bits |
| sw_in_valid | input | 4 | Incoming switch link valid, per edge |
| sw_in_data | input | 4x16 | Incoming switch link data |
| sw_in_ready | output | 4 | Incoming switch link ready |
| sw_out_valid | output | 4 | Outgoing switch link valid |
| sw_out_data | output | 4x16 | Outgoing switch link data |
| sw_out_ready | input | 4 | Outgoing switch link ready from neighbour |
| nb_in_valid | input | 4 | Incoming neighbour link valid |
| nb_in_data | input | 4x16 | Incoming neighbour link data |
| nb_in_ready | output | 4 | Incoming neighbour link ready |
| core_out_valid | input | 1 | Core result valid |
| core_out_data | input | 16 | Core result data |
| core_out_ready | output | 1 | Core result accepted |
| core_rd | input | 2 | FIFO A/B read (pop) request |
| core_rd_valid | output | 2 | FIFO A/B not empty |
| core_rd_data | output | 2x16 | FIFO A/B head word |

## Verification
Several properties are checked on every cycle. A word accepted on a switch input appears on each selected output edge one cycle later. A stalled output word stays stable. A FIFO is never written while full, and an empty FIFO does not become non-empty without a write. An input is never accepted while a selected transit stage is blocked. Routing never changes while enabled, and nothing is accepted while disabled. Data ordering through a full 32-word FIFO, the whole source-by-output routing sweep, broadcast delivery after a stall, and the neighbour and loopback paths can only be shown by the bench's scenarios.

// File: rtl/mesh_tile_pkg.sv
package mesh_tile_pkg;
  localparam int NEDGE  = 4;          // north, east, south, west
  localparam int NFIFO  = 2;          // two operand FIFOs
  localparam int NOUT   = NEDGE + NFIFO;
  localparam int SRC_CORE_IDX = NEDGE;
  localparam int SRC_NB_BASE  = NEDGE + 1;
  localparam int NSRC   = 2 * NEDGE + 1;
  localparam int SELW   = 3;

  typedef enum logic [SELW-1:0] {
    SEL_NONE  = 3'd0,
    SEL_NORTH = 3'd1,
    SEL_EAST  = 3'd2,
    SEL_SOUTH = 3'd3,
    SEL_WEST  = 3'd4,
    SEL_CORE  = 3'd5
  } sel_code_e;

  // Map a select code to a one-hot source vector.
  // Sources: 0..3 switch inputs, 4 core output, 5..8 neighbour inputs.
  function automatic logic [NSRC-1:0] source_onehot(input logic [SELW-1:0] code,
                                                     input logic from_nb);
    logic [NSRC-1:0] m;
    m = '0;
    case (code)
      SEL_NORTH, SEL_EAST, SEL_SOUTH, SEL_WEST: begin
        if (from_nb) m[SRC_NB_BASE + int'(code) - 1] = 1'b1;
        else         m[int'(code) - 1] = 1'b1;
      end
      SEL_CORE: m[SRC_CORE_IDX] = 1'b1;
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tile_route_ctrl.sv
module tile_route_ctrl
  import mesh_tile_pkg::*;
(
  input  logic                      en,
  input  logic [NOUT-1:0][NSRC-1:0] dest_map,
  input  logic [NOUT-1:0]           out_ready,
  input  logic [NSRC-1:0]           src_valid,
  output logic [NSRC-1:0]           src_ready,
  output logic [NSRC-1:0]           src_fire,
  output logic [NOUT-1:0]           out_load
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic used;
    logic all_rdy;
    always_comb begin
      used    = 1'b0;
      all_rdy = 1'b1;
      for (int j = 0; j < NOUT; j++) begin
        if (dest_map[j][s]) begin
          used    = 1'b1;
          all_rdy = all_rdy & out_ready[j];
        end
      end
    end
    assign src_ready[s] = en & used & all_rdy;
    assign src_fire[s]  = src_ready[s] & src_valid[s];
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    assign out_load[j] = |(dest_map[j] & src_fire);
  end
endmodule

// File: rtl/tile_hop_reg.sv
module tile_hop_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          dn_ready,
  output logic          up_ready,
  output logic          q_valid,
  output logic [DW-1:0] q_data
);
  assign up_ready = ~q_valid | dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= din;
    end else if (dn_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tile_core_fifo.sv
module tile_core_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic          full,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == (AW+1)'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rptr];
  assign pop      = pop_req & rd_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mesh_tile_router.sv
module mesh_tile_router
  import mesh_tile_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        cfg_we,
  input  logic [2:0]                  cfg_addr,
  input  logic [SELW-1:0]             cfg_sel,
  input  logic [NEDGE-1:0]            sw_in_valid,
  input  logic [NEDGE-1:0][DW-1:0]    sw_in_data,
  output logic [NEDGE-1:0]            sw_in_ready,
  output logic [NEDGE-1:0]            sw_out_valid,
  output logic [NEDGE-1:0][DW-1:0]    sw_out_data,
  input  logic [NEDGE-1:0]            sw_out_ready,
  input  logic [NEDGE-1:0]            nb_in_valid,
  input  logic [NEDGE-1:0][DW-1:0]    nb_in_data,
  output logic [NEDGE-1:0]            nb_in_ready,
  input  logic                        core_out_valid,
  input  logic [DW-1:0]               core_out_data,
  output logic                        core_out_ready,
  input  logic [NFIFO-1:0]            core_rd,
  output logic [NFIFO-1:0]            core_rd_valid,
  output logic [NFIFO-1:0][DW-1:0]    core_rd_data
);
  localparam logic [2:0] NB_ADDR = 3'(NOUT);

  // configuration store
  logic [NOUT-1:0][SELW-1:0] sel_q;
  logic [NFIFO-1:0]          nb_q;
  logic                      cfg_accept;

  assign cfg_accept = cfg_we & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      nb_q  <= '0;
    end else if (cfg_accept) begin
      if (cfg_addr < NB_ADDR) sel_q[cfg_addr] <= cfg_sel;
      else if (cfg_addr == NB_ADDR) nb_q <= cfg_sel[NFIFO-1:0];
    end
  end

  // source vectors
  logic [NSRC-1:0]          src_valid, src_ready, src_fire;
  logic [NSRC-1:0][DW-1:0]  src_data;
  logic [NOUT-1:0][NSRC-1:0] dest_map;
  logic [NOUT-1:0]          out_ready, out_load;

  assign src_valid = {nb_in_valid, core_out_valid, sw_in_valid};
  assign src_data  = {nb_in_data, core_out_data, sw_in_data};

  assign sw_in_ready    = src_ready[NEDGE-1:0];
  assign core_out_ready = src_ready[SRC_CORE_IDX];
  assign nb_in_ready    = src_ready[NSRC-1:SRC_NB_BASE];

  for (genvar j = 0; j < NOUT; j++) begin : g_map
    if (j < NEDGE) begin : g_edge
      assign dest_map[j] = source_onehot(sel_q[j], 1'b0);
    end else begin : g_fifo
      assign dest_map[j] = source_onehot(sel_q[j], nb_q[j-NEDGE]);
    end
  end

  tile_route_ctrl u_ctrl (
    .en        (en),
    .dest_map  (dest_map),
    .out_ready (out_ready),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_fire  (src_fire),
    .out_load  (out_load)
  );

  // observable internal events
  logic [NFIFO-1:0] fifo_push, fifo_full;

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    logic [DW-1:0] odata;
    always_comb begin
      odata = '0;
      for (int s = 0; s < NSRC; s++) begin
        if (dest_map[j][s]) odata = src_data[s];
      end
    end

    if (j < NEDGE) begin : g_hop
      tile_hop_reg #(.DW(DW)) u_hop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (out_load[j]),
        .din      (odata),
        .dn_ready (sw_out_ready[j]),
        .up_ready (out_ready[j]),
        .q_valid  (sw_out_valid[j]),
        .q_data   (sw_out_data[j])
      );
    end else begin : g_buf
      assign fifo_push[j-NEDGE] = out_load[j];
      assign out_ready[j]       = ~fifo_full[j-NEDGE];
      tile_core_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (out_load[j]),
        .din      (odata),
        .pop_req  (core_rd[j-NEDGE]),
        .full     (fifo_full[j-NEDGE]),
        .rd_valid (core_rd_valid[j-NEDGE]),
        .rd_data  (core_rd_data[j-NEDGE])
      );
    end
  end
endmodule

// File: rtl/mesh_tile_router_chk.sv
module mesh_tile_router_chk
  import mesh_tile_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      en,
  input logic [NEDGE-1:0]          sw_in_valid,
  input logic [NEDGE-1:0][DW-1:0]  sw_in_data,
  input logic [NEDGE-1:0]          sw_in_ready,
  input logic [NEDGE-1:0]          sw_out_valid,
  input logic [NEDGE-1:0][DW-1:0]  sw_out_data,
  input logic [NEDGE-1:0]          sw_out_ready,
  input logic [NEDGE-1:0]          nb_in_ready,
  input logic                      core_out_ready,
  input logic [NFIFO-1:0]          core_rd_valid,
  input logic [NFIFO-1:0]          fifo_push,
  input logic [NFIFO-1:0]          fifo_full,
  input logic [NOUT-1:0][SELW-1:0] sel_q,
  input logic [NFIFO-1:0]          nb_q
);
  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(sel_q) && $stable(nb_q)));

  // R10
  idle_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sw_in_ready == '0 && nb_in_ready == '0 && !core_out_ready));

  for (genvar j = 0; j < NEDGE; j++) begin : g_o
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_out_valid[j] && !sw_out_ready[j]) |=>
        (sw_out_valid[j] && $stable(sw_out_data[j])));
    for (genvar e = 0; e < NEDGE; e++) begin : g_i
      // R3
      one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_in_valid[e] && sw_in_ready[e] && sel_q[j] == 3'(e + 1)) |=>
          (sw_out_valid[j] && sw_out_data[j] == $past(sw_in_data[e])));
      // R5
      all_dest_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_in_ready[e] && sel_q[j] == 3'(e + 1)) |->
          (!sw_out_valid[j] || sw_out_ready[j]));
    end
  end

  for (genvar k = 0; k < NFIFO; k++) begin : g_f
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push[k] |-> !fifo_full[k]);
    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rd_valid[k] && !fifo_push[k]) |=> !core_rd_valid[k]);
  end
endmodule

bind mesh_tile_router mesh_tile_router_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en             (en),
  .sw_in_valid    (sw_in_valid),
  .sw_in_data     (sw_in_data),
  .sw_in_ready    (sw_in_ready),
  .sw_out_valid   (sw_out_valid),
  .sw_out_data    (sw_out_data),
  .sw_out_ready   (sw_out_ready),
  .nb_in_ready    (nb_in_ready),
  .core_out_ready (core_out_ready),
  .core_rd_valid  (core_rd_valid),
  .fifo_push      (fifo_push),
  .fifo_full      (fifo_full),
  .sel_q          (sel_q),
  .nb_q           (nb_q)
);

// File: tb/mesh_tile_router_bench.sv
module mesh_tile_router_bench;
  localparam int DW = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] sw_in_valid = '0;
  logic [3:0][DW-1:0] sw_in_data = '0;
  logic [3:0] sw_in_ready;
  logic [3:0] sw_out_valid;
  logic [3:0][DW-1:0] sw_out_data;
  logic [3:0] sw_out_ready = 4'hF;
  logic [3:0] nb_in_valid = '0;
  logic [3:0][DW-1:0] nb_in_data = '0;
  logic [3:0] nb_in_ready;
  logic core_out_valid = 1'b0;
  logic [DW-1:0] core_out_data = '0;
  logic core_out_ready;
  logic [1:0] core_rd = '0;
  logic [1:0] core_rd_valid;
  logic [1:0][DW-1:0] core_rd_data;

  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mesh_tile_router #(.DW(DW), .FIFO_DEPTH(DEPTH)) u_mesh_tile_router (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_sel(cfg_sel), .sw_in_valid(sw_in_valid), .sw_in_data(sw_in_data),
    .sw_in_ready(sw_in_ready), .sw_out_valid(sw_out_valid),
    .sw_out_data(sw_out_data), .sw_out_ready(sw_out_ready),
    .nb_in_valid(nb_in_valid), .nb_in_data(nb_in_data), .nb_in_ready(nb_in_ready),
    .core_out_valid(core_out_valid), .core_out_data(core_out_data),
    .core_out_ready(core_out_ready), .core_rd(core_rd),
    .core_rd_valid(core_rd_valid), .core_rd_data(core_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input int addr, input int sel);
    en = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = 3'(addr);
    cfg_sel = 3'(sel);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_clear();
    for (int a = 0; a < 7; a++) cfg_write(a, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    // R1: reset state
    #1;
    chk(sw_out_valid == 4'h0, "R1 out valid", 32'(sw_out_valid), 0);
    chk(core_rd_valid == 2'b00, "R1 fifo empty", 32'(core_rd_valid), 0);
    rst_n = 1'b1;
    en = 1'b1;
    tick();
    #1;
    chk(sw_in_ready == 4'h0 && nb_in_ready == 4'h0 && !core_out_ready,
        "R1 selects none", {sw_in_ready, nb_in_ready, 7'd0, core_out_ready}, 0);

    // R3 / R9 / R10: every source code to every output edge
    for (int j = 0; j < 4; j++) begin
      for (int c = 1; c <= 5; c++) begin
        logic [DW-1:0] w;
        logic [3:0] exp_rdy;
        w = 16'h1000 + 16'(j * 16 + c);
        exp_rdy = (c < 5) ? 4'(1 << (c - 1)) : 4'h0;
        cfg_clear();
        cfg_write(j, c);
        en = 1'b1;
        if (c < 5) begin
          sw_in_valid[c-1] = 1'b1;
          sw_in_data[c-1] = w;
        end else begin
          core_out_valid = 1'b1;
          core_out_data = w;
        end
        #1;
        chk(sw_in_ready == exp_rdy && core_out_ready == (c == 5),
            "R10 ready mask", {27'd0, core_out_ready, sw_in_ready},
            {27'd0, c == 5, exp_rdy});
        tick();
        sw_in_valid = '0;
        core_out_valid = 1'b0;
        #1;
        chk(sw_out_valid == 4'(1 << j), (c == 5) ? "R9 core to edge" : "R3 valid",
            32'(sw_out_valid), 32'(1 << j));
        chk(sw_out_data[j] == w, "R3 data", 32'(sw_out_data[j]), 32'(w));
        tick();
        #1;
        chk(sw_out_valid == 4'h0, "R3 drained", 32'(sw_out_valid), 0);
      end
    end

    // R4: stall holds the word, then old leaves and new loads at one edge
    cfg_clear();
    cfg_write(0, 4);
    en = 1'b1;
    sw_out_ready[0] = 1'b0;
    sw_in_valid[3] = 1'b1;
    sw_in_data[3] = 16'hAAAA;
    tick();
    sw_in_data[3] = 16'hBBBB;
    #1;
    chk(sw_in_ready[3] == 1'b0, "R4 refuse while stalled", 32'(sw_in_ready[3]), 0);
    tick();
    #1;
    chk(sw_out_valid[0] && sw_out_data[0] == 16'hAAAA, "R4 hold",
        32'(sw_out_data[0]), 32'hAAAA);
    sw_out_ready[0] = 1'b1;
    #1;
    chk(sw_in_ready[3] == 1'b1, "R4 ready on release", 32'(sw_in_ready[3]), 1);
    tick();
    sw_in_valid = '0;
    #1;
    chk(sw_out_valid[0] && sw_out_data[0] == 16'hBBBB, "R4 reload",
        32'(sw_out_data[0]), 32'hBBBB);
    tick();
    #1;
    chk(sw_out_valid == 4'h0, "R4 no duplicate", 32'(sw_out_valid), 0);

    // R5: broadcast north to east, south and FIFO A
    cfg_clear();
    cfg_write(1, 1);
    cfg_write(2, 1);
    cfg_write(4, 1);
    en = 1'b1;
    sw_out_ready[2] = 1'b0;
    sw_in_valid[0] = 1'b1;
    sw_in_data[0] = 16'h5151;
    tick();
    sw_in_data[0] = 16'h5252;
    #1;
    chk(sw_out_valid[1] && sw_out_valid[2] && sw_out_data[1] == 16'h5151,
        "R5 first word to all", 32'(sw_out_valid), 32'h6);
    chk(sw_in_ready[0] == 1'b0, "R5 blocked by one dest", 32'(sw_in_ready[0]), 0);
    tick();
    #1;
    chk(!sw_out_valid[1] && sw_out_valid[2] && sw_out_data[2] == 16'h5151,
        "R5 no partial delivery", 32'(sw_out_valid), 32'h4);
    sw_out_ready[2] = 1'b1;
    tick();
    sw_in_valid = '0;
    #1;
    chk(sw_out_data[1] == 16'h5252 && sw_out_data[2] == 16'h5252 &&
        sw_out_valid[1] && sw_out_valid[2], "R5 second word to all",
        32'(sw_out_data[2]), 32'h5252);
    chk(core_rd_valid[0] && core_rd_data[0] == 16'h5151, "R5 fifo first",
        32'(core_rd_data[0]), 32'h5151);
    core_rd[0] = 1'b1;
    tick();
    #1;
    chk(core_rd_valid[0] && core_rd_data[0] == 16'h5252, "R5 fifo second",
        32'(core_rd_data[0]), 32'h5252);
    tick();
    core_rd[0] = 1'b0;
    #1;
    chk(core_rd_valid[0] == 1'b0, "R5 fifo drained", 32'(core_rd_valid[0]), 0);

    // R6: fill FIFO B from east to 32 words, then read in order
    cfg_clear();
    cfg_write(5, 2);
    en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      sw_in_valid[1] = 1'b1;
      sw_in_data[1] = 16'hA000 + 16'(i);
      #1;
      chk(sw_in_ready[1] == 1'b1, "R6 accept while not full", 32'(sw_in_ready[1]), 1);
      tick();
    end
    sw_in_data[1] = 16'hDEAD;
    #1;
    chk(sw_in_ready[1] == 1'b0, "R6 full refuses", 32'(sw_in_ready[1]), 0);
    tick();
    sw_in_valid = '0;
    for (int i = 0; i < DEPTH; i++) begin
      core_rd[1] = 1'b1;
      #1;
      chk(core_rd_valid[1] && core_rd_data[1] == 16'hA000 + 16'(i), "R6 order",
          32'(core_rd_data[1]), 32'hA000 + 32'(i));
      tick();
    end
    core_rd[1] = 1'b0;
    #1;
    chk(core_rd_valid[1] == 1'b0, "R6 empty after 32", 32'(core_rd_valid[1]), 0);

    // R7: reads on empty are ignored
    core_rd[1] = 1'b1;
    repeat (3) tick();
    core_rd[1] = 1'b0;
    #1;
    chk(core_rd_valid[1] == 1'b0, "R7 still empty", 32'(core_rd_valid[1]), 0);
    sw_in_valid[1] = 1'b1;
    sw_in_data[1] = 16'hC0DE;
    tick();
    sw_in_valid = '0;
    #1;
    chk(core_rd_valid[1] && core_rd_data[1] == 16'hC0DE, "R7 next word intact",
        32'(core_rd_data[1]), 32'hC0DE);
    core_rd[1] = 1'b1;
    tick();
    core_rd[1] = 1'b0;
    #1;
    chk(core_rd_valid[1] == 1'b0, "R7 single pop", 32'(core_rd_valid[1]), 0);

    // R8: neighbour link from south into FIFO A
    cfg_clear();
    cfg_write(6, 1);
    cfg_write(4, 3);
    en = 1'b1;
    nb_in_valid[2] = 1'b1;
    nb_in_data[2] = 16'h7E57;
    #1;
    chk(nb_in_ready == 4'b0100 && sw_in_ready == 4'h0, "R8 neighbour ready",
        {24'd0, nb_in_ready, sw_in_ready}, 32'h40);
    tick();
    nb_in_valid = '0;
    #1;
    chk(core_rd_valid[0] && core_rd_data[0] == 16'h7E57, "R8 neighbour word",
        32'(core_rd_data[0]), 32'h7E57);
    core_rd[0] = 1'b1;
    tick();
    core_rd[0] = 1'b0;

    // R9: core output loopback into FIFO B
    cfg_clear();
    cfg_write(5, 5);
    en = 1'b1;
    core_out_valid = 1'b1;
    core_out_data = 16'h1009;
    #1;
    chk(core_out_ready == 1'b1, "R9 loopback ready", 32'(core_out_ready), 1);
    tick();
    core_out_valid = 1'b0;
    #1;
    chk(core_rd_valid[1] && core_rd_data[1] == 16'h1009, "R9 loopback word",
        32'(core_rd_data[1]), 32'h1009);
    core_rd[1] = 1'b1;
    tick();
    core_rd[1] = 1'b0;

    // R2: a write while enabled is ignored
    cfg_clear();
    en = 1'b1;
    cfg_we = 1'b1;
    cfg_addr = 3'd0;
    cfg_sel = 3'd1;
    tick();
    cfg_we = 1'b0;
    sw_in_valid[0] = 1'b1;
    sw_in_data[0] = 16'hFACE;
    #1;
    chk(sw_in_ready[0] == 1'b0, "R2 write ignored when enabled", 32'(sw_in_ready[0]), 0);
    tick();
    #1;
    chk(sw_out_valid == 4'h0, "R2 no route", 32'(sw_out_valid), 0);
    sw_in_valid = '0;

    // R10: disabled router accepts nothing even when routed
    cfg_write(0, 1);
    sw_in_valid[0] = 1'b1;
    #1;
    chk(sw_in_ready == 4'h0, "R10 disabled", 32'(sw_in_ready), 0);
    tick();
    #1;
    chk(sw_out_valid == 4'h0, "R10 nothing moved", 32'(sw_out_valid), 0);
    en = 1'b1;
    #1;
    chk(sw_in_ready[0] == 1'b1, "R2 write taken when idle", 32'(sw_in_ready[0]), 1);
    sw_in_valid = '0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule